// File: doc/BRIEF.md
# Two-Wire Bus Byte Master

This block is a byte-level master for a two-wire serial bus with open-drain clock and data lines. Software drives it through three small registers: a control register, a data register and an interrupt-enable bit. A read-only status code reports the outcome of each step. Software issues one bus step at a time: a start condition, a stop condition, the transmission of one byte, or the reception of one byte that the master then acknowledges or refuses. When the step is done, the engine raises an interrupt flag and loads a fixed numeric status code. Software checks that code before it issues the next step.

The engine never outputs a high level on either line. It only enables a pull-down (`scl_oe`, `sda_oe`) and it reads the real line levels back on `scl_i` and `sda_i`. Bus timing comes from a bit-rate strobe `tick`, produced by a divider outside the block. Each bit lasts four strobe phases. If a target holds the clock line low after the engine has released it, the engine waits. There is no stream interface. A register write is a single-cycle strobe that is always accepted, so there is no back-pressure. Arbitration between several masters and target-mode operation are not part of this block.

Control register bits: bit 7 clock enable (stored only), bit 6 bus enable, bit 5 start request, bit 4 stop request, bit 3 interrupt flag, bit 2 acknowledge enable, bits 1:0 read as zero. Register select `reg_sel`: 0 is control, 1 is data, 2 is interrupt enable (bit 0), and 3 is ignored. Bit 0 of the first byte after a start selects the direction: 1 means read.

Top module: `twb_master`

## Requirements
- R1: After reset, the status reads 0xF8, the control and data registers read 0x00, neither line is pulled low, and `irq_o` is low.
- R2: A control write stores bits 7, 6 and 2 as written. Writing 0 to bit 3 clears the interrupt flag. Writing 1 to bit 3 never sets the flag. Data writes read back unchanged.
- R3: With bus enable set and a start requested on an idle bus, the engine pulls SDA low while SCL is high and then pulls SCL low. It then sets the flag, loads status 0x08 and clears the start request.
- R4: If SDA reads low when an idle start begins, the start is refused. The status stays 0xF8, the flag stays clear, the start request is cleared and neither line is driven.
- R5: A start requested while the engine holds the bus produces a repeated start with status 0x10.
- R6: The first byte after a start is shifted out MSB first. SDA does not change while SCL is high. The status becomes 0x18 (acknowledged) or 0x20 (refused) for a write address (bit 0 = 0), and 0x40 or 0x48 for a read address (bit 0 = 1).
- R7: Later bytes of a write give status 0x28 when acknowledged and 0x30 when refused.
- R8: Bytes of a read are received MSB first into the data register. The master pulls SDA low on the acknowledge bit only when bit 2 is set. The status becomes 0x50 after an acknowledge and 0x58 after a refusal.
- R9: While the flag is set, SCL stays pulled low and no bus step starts.
- R10: A stop request while the bus is held makes SDA rise while SCL is high. The status becomes 0xF8, both lines are released, the stop request clears and the flag is not set.
- R11: `irq_o` is high exactly when interrupt enable is set and the status is not 0xF8.
- R12: After the engine releases SCL within a bit, it does not advance until `scl_i` reads high.
- R13: With bus enable clear, a start request stays pending and no bus activity occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Quarter-bit strobe from the rate divider |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 data, 2 interrupt enable) |
| reg_wdata | input | 8 | Write data |
| ctl_q | output | 8 | Control register view |
| data_q | output | 8 | Data register view |
| status_q | output | 8 | Status code |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | Sampled clock line |
| sda_i | input | 1 | Sampled data line |
| scl_oe | output | 1 | Clock line pull-down enable |
| sda_oe | output | 1 | Data line pull-down enable |

## Verification
A start or stop takes four strobe phases. A byte takes thirty-six phases, and any clock stretching adds to that. The flag and the status code change on the same edge as the last phase, and the cycle after a flag-clearing write is the earliest point at which a step can begin. The bench does not count out these delays. It polls the flag, or a status of 0xF8 for a stop, on falling clock edges with a bounded wait. It then checks the status, the data, and what its bus-target model captured. For conditions where nothing may happen (refused start, bus disabled, flag held), it waits several byte times and then checks that the state is unchanged.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned PH_N    = 4;
  localparam int unsigned PH_W    = $clog2(PH_N);
  localparam int unsigned HOLD_PH = 2;

  // control bit positions
  localparam int unsigned C_CE  = 7;
  localparam int unsigned C_EN  = 6;
  localparam int unsigned C_STA = 5;
  localparam int unsigned C_STP = 4;
  localparam int unsigned C_FLG = 3;
  localparam int unsigned C_AAK = 2;

  // register selects
  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_IE   = 2'd2;

  // status codes
  localparam logic [7:0] ST_IDLE   = 8'hF8;
  localparam logic [7:0] ST_START  = 8'h08;
  localparam logic [7:0] ST_RSTART = 8'h10;
  localparam logic [7:0] ST_WA_ACK = 8'h18;
  localparam logic [7:0] ST_WA_NAK = 8'h20;
  localparam logic [7:0] ST_WD_ACK = 8'h28;
  localparam logic [7:0] ST_WD_NAK = 8'h30;
  localparam logic [7:0] ST_RA_ACK = 8'h40;
  localparam logic [7:0] ST_RA_NAK = 8'h48;
  localparam logic [7:0] ST_RD_ACK = 8'h50;
  localparam logic [7:0] ST_RD_NAK = 8'h58;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_HELD, SQ_START, SQ_RSTART, SQ_STOP, SQ_BYTE
  } seq_e;
endpackage

// File: rtl/twb_regs.sv
module twb_regs
  import twb_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   sel,
  input  logic [W-1:0] wdata,
  input  logic         ev_done,
  input  logic         ev_code_we,
  input  logic [7:0]   ev_code,
  input  logic         rx_we,
  input  logic [W-1:0] rx_byte,
  input  logic         clr_sta,
  input  logic         clr_stp,
  output logic [7:0]   ctl_q,
  output logic [W-1:0] data_q,
  output logic [7:0]   status_q,
  output logic         ie_q
);
  logic ce, en, sta, stp, flg, aak;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce <= 1'b0; en <= 1'b0; sta <= 1'b0; stp <= 1'b0;
      flg <= 1'b0; aak <= 1'b0;
      data_q   <= '0;
      status_q <= ST_IDLE;
      ie_q     <= 1'b0;
    end else begin
      if (we && sel == SEL_CTL) begin
        ce  <= wdata[C_CE];
        en  <= wdata[C_EN];
        sta <= wdata[C_STA];
        stp <= wdata[C_STP];
        flg <= flg & wdata[C_FLG];
        aak <= wdata[C_AAK];
      end
      if (clr_sta) sta <= 1'b0;
      if (clr_stp) stp <= 1'b0;
      if (ev_done) flg <= 1'b1;
      if (we && sel == SEL_DATA) data_q <= wdata;
      if (rx_we) data_q <= rx_byte;
      if (we && sel == SEL_IE) ie_q <= wdata[0];
      if (ev_code_we) status_q <= ev_code;
    end
  end

  always_comb begin
    ctl_q        = '0;
    ctl_q[C_CE]  = ce;
    ctl_q[C_EN]  = en;
    ctl_q[C_STA] = sta;
    ctl_q[C_STP] = stp;
    ctl_q[C_FLG] = flg;
    ctl_q[C_AAK] = aak;
  end
endmodule

// File: rtl/twb_phase.sv
module twb_phase
  import twb_pkg::*;
#(
  parameter int unsigned N    = PH_N,
  parameter int unsigned HOLD = HOLD_PH,
  parameter int unsigned W    = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         scl_in,
  output logic [W-1:0] ph,
  output logic         step
);
  localparam logic [W-1:0] LAST = W'(N - 1);
  localparam logic [W-1:0] HPH  = W'(HOLD);

  logic hold;
  assign hold = (ph == HPH) && !scl_in;
  assign step = tick && run && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n)       ph <= '0;
    else if (!run)    ph <= '0;
    else if (step)    ph <= (ph == LAST) ? '0 : ph + 1'b1;
  end
endmodule

// File: rtl/twb_seq.sv
module twb_seq
  import twb_pkg::*;
#(
  parameter int unsigned W  = REG_W,
  parameter int unsigned PW = PH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          flg,
  input  logic          sta,
  input  logic          stp,
  input  logic          aak,
  input  logic [W-1:0]  data_q,
  input  logic          step,
  input  logic [PW-1:0] ph,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          run,
  output logic          in_byte,
  output logic          ev_done,
  output logic          ev_code_we,
  output logic [7:0]    ev_code,
  output logic          rx_we,
  output logic [W-1:0]  rx_byte,
  output logic          clr_sta,
  output logic          clr_stp
);
  localparam int unsigned SW = $clog2(W + 1);
  localparam logic [SW-1:0] ACK_SLOT = SW'(W);
  localparam logic [PW-1:0] P0 = PW'(0);
  localparam logic [PW-1:0] P1 = PW'(1);
  localparam logic [PW-1:0] P2 = PW'(2);
  localparam logic [PW-1:0] P3 = PW'(3);

  seq_e          st;
  logic [SW-1:0] slot;
  logic [W-1:0]  shreg;
  logic          is_addr, rd_mode, acked;
  logic          rx_now, last_slot, drive, bus_free;
  logic [7:0]    byte_code;

  assign rx_now    = !is_addr && rd_mode;
  assign last_slot = (slot == ACK_SLOT);
  assign bus_free  = sda_in && scl_in;
  assign run       = (st == SQ_START) || (st == SQ_RSTART) ||
                     (st == SQ_STOP)  || (st == SQ_BYTE);
  assign in_byte   = (st == SQ_BYTE);
  assign rx_byte   = shreg;

  always_comb begin
    if (last_slot) drive = rx_now ? aak : 1'b0;
    else           drive = rx_now ? 1'b0 : !shreg[W-1];
  end

  always_comb begin
    if (is_addr)
      byte_code = rd_mode ? (acked ? ST_RA_ACK : ST_RA_NAK)
                          : (acked ? ST_WA_ACK : ST_WA_NAK);
    else
      byte_code = rd_mode ? (acked ? ST_RD_ACK : ST_RD_NAK)
                          : (acked ? ST_WD_ACK : ST_WD_NAK);
  end

  // completion events, same edge as the state change
  always_comb begin
    ev_done = 1'b0; ev_code_we = 1'b0; ev_code = ST_IDLE;
    rx_we = 1'b0; clr_sta = 1'b0; clr_stp = 1'b0;
    unique case (st)
      SQ_IDLE: begin
        if (en && stp && !sta) clr_stp = 1'b1;
      end
      SQ_START: begin
        if (step && ph == P0 && !bus_free) clr_sta = 1'b1;
        if (step && ph == P3) begin
          clr_sta = 1'b1; ev_done = 1'b1; ev_code_we = 1'b1; ev_code = ST_START;
        end
      end
      SQ_RSTART: begin
        if (step && ph == P3) begin
          clr_sta = 1'b1; ev_done = 1'b1; ev_code_we = 1'b1; ev_code = ST_RSTART;
        end
      end
      SQ_STOP: begin
        if (step && ph == P3) begin
          clr_stp = 1'b1; ev_code_we = 1'b1; ev_code = ST_IDLE;
        end
      end
      SQ_BYTE: begin
        if (step && ph == P3 && last_slot) begin
          ev_done = 1'b1; ev_code_we = 1'b1; ev_code = byte_code;
          rx_we = rx_now;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SQ_IDLE; slot <= '0; shreg <= '0;
      is_addr <= 1'b0; rd_mode <= 1'b0; acked <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (en && sta && !flg) st <= SQ_START;
        end
        SQ_START: if (step) begin
          unique case (ph)
            P0: if (!bus_free) st <= SQ_IDLE;
            P1: sda_oe <= 1'b1;
            P2: scl_oe <= 1'b1;
            P3: begin st <= SQ_HELD; is_addr <= 1'b1; end
            default: ;
          endcase
        end
        SQ_HELD: begin
          if (en && !flg) begin
            if (stp)      st <= SQ_STOP;
            else if (sta) st <= SQ_RSTART;
            else begin
              st    <= SQ_BYTE;
              slot  <= '0;
              shreg <= data_q;
              if (is_addr) rd_mode <= data_q[0];
            end
          end
        end
        SQ_RSTART: if (step) begin
          unique case (ph)
            P0: sda_oe <= 1'b0;
            P1: scl_oe <= 1'b0;
            P2: sda_oe <= 1'b1;
            P3: begin scl_oe <= 1'b1; st <= SQ_HELD; is_addr <= 1'b1; end
            default: ;
          endcase
        end
        SQ_STOP: if (step) begin
          unique case (ph)
            P0: sda_oe <= 1'b1;
            P1: scl_oe <= 1'b0;
            P2: sda_oe <= 1'b0;
            P3: st <= SQ_IDLE;
            default: ;
          endcase
        end
        SQ_BYTE: if (step) begin
          unique case (ph)
            P0: sda_oe <= drive;
            P1: scl_oe <= 1'b0;
            P2: begin
              if (last_slot)   acked <= !sda_in;
              else if (rx_now) shreg <= {shreg[W-2:0], sda_in};
            end
            P3: begin
              scl_oe <= 1'b1;
              if (!rx_now && !last_slot) shreg <= {shreg[W-2:0], 1'b0};
              if (last_slot) begin
                st      <= SQ_HELD;
                is_addr <= 1'b0;
              end else begin
                slot <= slot + 1'b1;
              end
            end
            default: ;
          endcase
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twb_master.sv
module twb_master
  import twb_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reg_we,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [7:0]   ctl_q,
  output logic [W-1:0] data_q,
  output logic [7:0]   status_q,
  output logic         irq_o,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         scl_oe,
  output logic         sda_oe
);
  logic            ie_q, ev_done, ev_code_we, rx_we, clr_sta, clr_stp;
  logic [7:0]      ev_code;
  logic [W-1:0]    rx_byte;
  logic            run, step, seq_in_byte;
  logic [PH_W-1:0] ph;

  twb_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .ev_done(ev_done), .ev_code_we(ev_code_we), .ev_code(ev_code),
    .rx_we(rx_we), .rx_byte(rx_byte), .clr_sta(clr_sta), .clr_stp(clr_stp),
    .ctl_q(ctl_q), .data_q(data_q), .status_q(status_q), .ie_q(ie_q)
  );

  twb_phase #(.N(PH_N), .HOLD(HOLD_PH), .W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .scl_in(scl_i),
    .ph(ph), .step(step)
  );

  twb_seq #(.W(W), .PW(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .en(ctl_q[C_EN]), .flg(ctl_q[C_FLG]), .sta(ctl_q[C_STA]),
    .stp(ctl_q[C_STP]), .aak(ctl_q[C_AAK]), .data_q(data_q),
    .step(step), .ph(ph), .scl_in(scl_i), .sda_in(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .run(run), .in_byte(seq_in_byte),
    .ev_done(ev_done), .ev_code_we(ev_code_we), .ev_code(ev_code),
    .rx_we(rx_we), .rx_byte(rx_byte), .clr_sta(clr_sta), .clr_stp(clr_stp)
  );

  assign irq_o = ie_q && (status_q != ST_IDLE);
endmodule

// File: rtl/twb_master_chk.sv
module twb_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_q,
  input logic [7:0] status_q,
  input logic       irq_o,
  input logic       scl_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       in_byte
);
  assert_flag_holds_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[3] |-> scl_oe);

  assert_flag_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[3]) |-> (status_q inside {8'h08, 8'h10, 8'h18, 8'h20, 8'h28,
                                          8'h30, 8'h40, 8'h48, 8'h50, 8'h58}));

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'hF8 && $past(status_q) != 8'hF8) |-> (!scl_oe && !sda_oe));

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == 8'hF8) |-> !irq_o);

  assert_sda_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && $past(in_byte) && scl_i && $past(scl_i)) |-> $stable(sda_oe));
endmodule

bind twb_master twb_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .status_q(status_q), .irq_o(irq_o),
  .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .in_byte(seq_in_byte)
);

// File: tb/twb_master_test.sv
`timescale 1ns/1ps
module twb_master_test;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] ctl_q, data_q, status_q;
  logic irq_o, scl_oe, sda_oe, scl_i, sda_i, tick;
  logic stretch = 1'b0, tgt_hold = 1'b0, tgt_ack = 1'b0, tgt_reading = 1'b0;
  logic [7:0] tgt_tx = 8'h00, tgt_rx = 8'h00;
  logic tgt_mack = 1'b0, tgt_low, prev_scl = 1'b1, prev_sda = 1'b1;
  logic [3:0] tgt_bit = 4'd15;
  logic [1:0] tdiv = 2'd0;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  // bus target model: open-drain lines
  always_comb begin
    if (tgt_bit == 4'd8)     tgt_low = !tgt_reading && tgt_ack;
    else if (tgt_bit < 4'd8) tgt_low = tgt_reading && !tgt_tx[3'(7 - tgt_bit)];
    else                     tgt_low = 1'b0;
  end
  assign scl_i = !(scl_oe || stretch);
  assign sda_i = !(sda_oe || tgt_low || tgt_hold);

  always @(negedge clk) begin
    if (prev_sda && !sda_i && scl_i && prev_scl) tgt_bit <= 4'd15;
    else if (prev_scl && !scl_i)
      tgt_bit <= (tgt_bit == 4'd15 || tgt_bit == 4'd8) ? 4'd0 : tgt_bit + 4'd1;
    if (!prev_scl && scl_i) begin
      if (tgt_bit < 4'd8)       tgt_rx <= {tgt_rx[6:0], sda_i};
      else if (tgt_bit == 4'd8) tgt_mack <= !sda_i;
    end
    prev_scl <= scl_i;
    prev_sda <= sda_i;
  end

  twb_master uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctl_q(ctl_q), .data_q(data_q), .status_q(status_q),
    .irq_o(irq_o), .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    check8(req, {7'd0, act}, {7'd0, exp});
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    while (!ctl_q[3] && n < 3000) begin @(negedge clk); n++; end
    check1({req, " flag"}, ctl_q[3], 1'b1);
  endtask

  task automatic do_stop(input string req);
    int n = 0;
    wr(2'd0, 8'h50);
    while (status_q != 8'hF8 && n < 3000) begin @(negedge clk); n++; end
    idle(2);
    check8({req, " stop status"}, status_q, 8'hF8);
    check1({req, " stop flag"}, ctl_q[3], 1'b0);
    check1({req, " stop req cleared"}, ctl_q[4], 1'b0);
    check1({req, " stop scl"}, scl_oe, 1'b0);
    check1({req, " stop sda"}, sda_oe, 1'b0);
  endtask

  task automatic send(input string req, input logic [7:0] b, input logic [7:0] ctl,
                      input logic [7:0] exp);
    wr(2'd1, b);
    wr(2'd0, ctl);
    wait_flag(req);
    check8({req, " status"}, status_q, exp);
  endtask

  task automatic t_reset;
    check8("R1 status", status_q, 8'hF8);
    check8("R1 ctl", ctl_q, 8'h00);
    check8("R1 data", data_q, 8'h00);
    check1("R1 scl", scl_oe, 1'b0);
    check1("R1 sda", sda_oe, 1'b0);
    check1("R1 irq", irq_o, 1'b0);
  endtask

  task automatic t_ctl_bits;
    wr(2'd0, 8'h8C);
    check8("R2 stored bits, flag not set", ctl_q, 8'h84);
    wr(2'd0, 8'h00);
    check8("R2 cleared", ctl_q, 8'h00);
    wr(2'd1, 8'h6B);
    check8("R2 data readback", data_q, 8'h6B);
  endtask

  task automatic t_enable_gate;
    wr(2'd0, 8'h20);
    idle(200);
    check8("R13 start pending", ctl_q, 8'h20);
    check8("R13 status", status_q, 8'hF8);
    check1("R13 scl", scl_oe, 1'b0);
    check1("R13 sda", sda_oe, 1'b0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_refuse;
    tgt_hold = 1'b1;
    idle(4);
    wr(2'd0, 8'h60);
    idle(100);
    check8("R4 status", status_q, 8'hF8);
    check8("R4 ctl", ctl_q, 8'h40);
    check1("R4 scl", scl_oe, 1'b0);
    check1("R4 sda", sda_oe, 1'b0);
    tgt_hold = 1'b0;
    idle(4);
  endtask

  task automatic t_write;
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h60);
    wait_flag("R3");
    check8("R3 status", status_q, 8'h08);
    check1("R3 start cleared", ctl_q[5], 1'b0);
    check1("R11 irq after start", irq_o, 1'b1);
    idle(300);
    check1("R9 scl held", scl_oe, 1'b1);
    check8("R9 status unchanged", status_q, 8'h08);
    tgt_ack = 1'b1;
    send("R6 write addr ack", 8'hA4, 8'h40, 8'h18);
    check8("R6 bits on bus", tgt_rx, 8'hA4);
    send("R7 write data ack", 8'h3C, 8'h40, 8'h28);
    check8("R7 bits on bus", tgt_rx, 8'h3C);
    wr(2'd2, 8'h00);
    check1("R11 irq masked", irq_o, 1'b0);
    wr(2'd2, 8'h01);
    check1("R11 irq unmasked", irq_o, 1'b1);
    tgt_ack = 1'b0;
    send("R7 write data nack", 8'h81, 8'h40, 8'h30);
    do_stop("R10");
    check1("R11 irq idle", irq_o, 1'b0);
  endtask

  task automatic t_addr_nack;
    tgt_ack = 1'b0;
    wr(2'd0, 8'h60);
    wait_flag("R3");
    send("R6 write addr nack", 8'hA4, 8'h40, 8'h20);
    do_stop("R10");
  endtask

  task automatic t_read;
    tgt_ack = 1'b1;
    wr(2'd0, 8'h60);
    wait_flag("R3");
    send("R6 read addr ack", 8'hA5, 8'h40, 8'h40);
    tgt_reading = 1'b1;
    tgt_tx = 8'h96;
    wr(2'd0, 8'h44);
    wait_flag("R8");
    check8("R8 rx ack status", status_q, 8'h50);
    check8("R8 rx data", data_q, 8'h96);
    check1("R8 master ack seen", tgt_mack, 1'b1);
    tgt_tx = 8'h5B;
    wr(2'd0, 8'h40);
    wait_flag("R8");
    check8("R8 rx nack status", status_q, 8'h58);
    check8("R8 rx data last", data_q, 8'h5B);
    check1("R8 master nack seen", tgt_mack, 1'b0);
    tgt_reading = 1'b0;
    tgt_ack = 1'b0;
    wr(2'd0, 8'h60);
    wait_flag("R5");
    check8("R5 repeated start", status_q, 8'h10);
    send("R6 read addr nack", 8'hA5, 8'h40, 8'h48);
    do_stop("R10");
  endtask

  task automatic t_stretch;
    tgt_ack = 1'b1;
    wr(2'd0, 8'h60);
    wait_flag("R3");
    send("R6 write addr ack", 8'hA4, 8'h40, 8'h18);
    stretch = 1'b1;
    wr(2'd1, 8'h55);
    wr(2'd0, 8'h40);
    idle(400);
    check1("R12 waits while stretched", ctl_q[3], 1'b0);
    check8("R12 status unchanged", status_q, 8'h18);
    stretch = 1'b0;
    wait_flag("R12");
    check8("R12 status after release", status_q, 8'h28);
    check8("R12 bits on bus", tgt_rx, 8'h55);
    do_stop("R10");
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_ctl_bits();
    t_enable_gate();
    t_refuse();
    t_write();
    t_addr_nack();
    t_read();
    t_stretch();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule